// File: doc/BRIEF.md
# Banked Edge-Interrupt Controller

This block watches a set of asynchronous external lines, grouped into banks of 32, and turns selected signal transitions into interrupt requests and wake-up events. Each line has its own edge detector. Software chooses, per line, whether a rising transition, a falling transition or both are recorded. Rising and falling detections latch into two separate pending registers, so software can always tell which kind of edge occurred.

Every line has two independent masks. One gates the latched state onto a per-line interrupt request. The other gates the same state onto a per-line wake-up event. Each bank also drives a single combined interrupt, the OR of its line requests. Software clears pending bits one at a time with write-one-to-clear, which never disturbs any other line. A software-trigger register can raise a line's event on demand, for example to retrigger a request that was consumed too early.

The register interface is a word-addressed, single-cycle write port with a combinational read. Each bank occupies eight words (a stride of 0x20 bytes). The upper address bits select the bank and the low three bits select the register.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every mask, trigger enable and pending bit reads 0, and all request, wake and bank outputs are 0.
- R2: Each input passes through a two-stage synchroniser. A rising transition on a line whose rising-trigger bit (word offset 2) is 1 sets that line's rising-pending bit (offset 5) on the third clock edge after the new level is first sampled.
- R3: A falling transition on a line whose falling-trigger bit (offset 3) is 1 sets that line's falling-pending bit (offset 6). When both enables are set, a pulse latches into both registers.
- R4: A transition whose trigger enable is 0 latches nothing.
- R5: Writing a 1 to a pending bit clears only that bit. Writing 0 to a pending bit has no effect, and pending bits on other lines are kept.
- R6: When a new edge and a clear of the same pending bit land in the same cycle, the bit stays set.
- R7: Writing a 1 to a software-trigger bit (offset 4) sets that line's rising-pending bit whatever its trigger enables are. Writing 0 has no effect, and the register reads 0.
- R8: irq_line equals (rising pending OR falling pending) AND interrupt mask (offset 0). wake_line uses the same pending OR gated by the event mask (offset 1). irq_bank[b] is the OR of bank b's irq_line bits.
- R9: Bank b occupies word addresses 8*b to 8*b+7. Mask and trigger registers read back what was written. Offset 7, and any bank index at or above the bank count, read 0, and writes there change nothing.
- R10: Mask and trigger registers change only when they are written, so clears and software triggers leave them intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_in | input | NUM_LINES (96) | Asynchronous external lines, bank b on bits 32b..32b+31 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (6) | Word address: bank in upper bits, register in low 3 bits |
| reg_wdata | input | BANK_W (32) | Write data |
| reg_rdata | output | BANK_W (32) | Combinational read data for reg_addr |
| irq_line | output | NUM_LINES (96) | Per-line masked interrupt request |
| wake_line | output | NUM_LINES (96) | Per-line masked wake-up event |
| irq_bank | output | NUM_BANKS (3) | Per-bank combined interrupt |

## Verification
A single-line rise, then fall, shows the exact synchroniser latency and separates rising from falling latching. A transition on a line with its trigger disabled shows that enables gate detection. A pulse on a line with both enables set shows that the two pending registers are independent. An edge timed to meet a clear in the same cycle shows whether set wins or the edge is lost. A long stretch of pseudo-random activity on all 96 lines, compared every clock against a behavioural model, exposes crosstalk between lines and banks and any mask or bank-OR error.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int OFS_W = 3;  // eight words per bank

  typedef enum logic [OFS_W-1:0] {
    SEL_IMASK  = 3'd0,
    SEL_EMASK  = 3'd1,
    SEL_RTRIG  = 3'd2,
    SEL_FTRIG  = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_RPEND  = 3'd5,
    SEL_FPEND  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise_evt,
  output logic [W-1:0] fall_evt
);
  logic [W-1:0] meta_q, stable_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
      prev_q   <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
      prev_q   <= stable_q;
    end
  end

  assign rise_evt = stable_q & ~prev_q;
  assign fall_evt = ~stable_q & prev_q;
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank import edge_irq_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise_evt,
  input  logic [W-1:0] fall_evt,
  output logic [W-1:0] imask,
  output logic [W-1:0] emask,
  output logic [W-1:0] rtrig,
  output logic [W-1:0] ftrig,
  output logic [W-1:0] rpend,
  output logic [W-1:0] fpend,
  output logic [W-1:0] sw_set,
  output logic [W-1:0] rclr,
  output logic [W-1:0] fclr,
  output logic [W-1:0] irq_out,
  output logic [W-1:0] wake_out,
  output logic         bank_irq
);
  // set has priority over clear
  function automatic logic [W-1:0] pend_next(logic [W-1:0] cur, logic [W-1:0] set,
                                             logic [W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [W-1:0] gate_req(logic [W-1:0] rp, logic [W-1:0] fp,
                                            logic [W-1:0] mask);
    return (rp | fp) & mask;
  endfunction

  function automatic logic [W-1:0] strobe(logic we, reg_sel_e s, reg_sel_e want,
                                          logic [W-1:0] d);
    return (we && s == want) ? d : '0;
  endfunction

  assign sw_set = strobe(wr_en, sel, SEL_SWTRIG, wdata);
  assign rclr   = strobe(wr_en, sel, SEL_RPEND, wdata);
  assign fclr   = strobe(wr_en, sel, SEL_FPEND, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask <= '0;
      emask <= '0;
      rtrig <= '0;
      ftrig <= '0;
      rpend <= '0;
      fpend <= '0;
    end else begin
      rpend <= pend_next(rpend, (rise_evt & rtrig) | sw_set, rclr);
      fpend <= pend_next(fpend, fall_evt & ftrig, fclr);
      if (wr_en) begin
        case (sel)
          SEL_IMASK: imask <= wdata;
          SEL_EMASK: emask <= wdata;
          SEL_RTRIG: rtrig <= wdata;
          SEL_FTRIG: ftrig <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq_out  = gate_req(rpend, fpend, imask);
  assign wake_out = gate_req(rpend, fpend, emask);
  assign bank_irq = |irq_out;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl import edge_irq_pkg::*; #(
  parameter  int NUM_BANKS = 3,
  parameter  int BANK_W    = 32,
  parameter  int ADDR_W    = 6,
  localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_in,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [BANK_W-1:0]    reg_wdata,
  output logic [BANK_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_line,
  output logic [NUM_LINES-1:0] wake_line,
  output logic [NUM_BANKS-1:0] irq_bank
);
  localparam int BIDX_W = ADDR_W - OFS_W;

  logic [BIDX_W-1:0] bank_idx;
  logic              bank_hit;
  reg_sel_e          sel;
  logic [NUM_BANKS-1:0] bank_we;

  assign bank_idx = reg_addr[ADDR_W-1:OFS_W];
  assign sel      = reg_sel_e'(reg_addr[OFS_W-1:0]);
  assign bank_hit = int'(bank_idx) < NUM_BANKS;

  // Named internal events, visible to the checker
  logic [NUM_LINES-1:0] rise_evt, fall_evt;
  logic [NUM_LINES-1:0] im_all, em_all, rt_all, ft_all, rp_all, fp_all;
  logic [NUM_LINES-1:0] sw_set_all, rclr_all, fclr_all;
  logic                 cfg_wr;

  logic [NUM_BANKS-1:0][BANK_W-1:0] im_b, em_b, rt_b, ft_b, rp_b, fp_b;
  logic [NUM_BANKS-1:0][BANK_W-1:0] sw_b, rc_b, fc_b, irq_b, wake_b;

  assign cfg_wr = reg_wr && bank_hit &&
                  (sel inside {SEL_IMASK, SEL_EMASK, SEL_RTRIG, SEL_FTRIG});

  edge_irq_sync #(.W(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (lines_in),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = reg_wr && bank_hit && (int'(bank_idx) == b);

    edge_irq_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_we[b]),
      .sel      (sel),
      .wdata    (reg_wdata),
      .rise_evt (rise_evt[b*BANK_W +: BANK_W]),
      .fall_evt (fall_evt[b*BANK_W +: BANK_W]),
      .imask    (im_b[b]),
      .emask    (em_b[b]),
      .rtrig    (rt_b[b]),
      .ftrig    (ft_b[b]),
      .rpend    (rp_b[b]),
      .fpend    (fp_b[b]),
      .sw_set   (sw_b[b]),
      .rclr     (rc_b[b]),
      .fclr     (fc_b[b]),
      .irq_out  (irq_b[b]),
      .wake_out (wake_b[b]),
      .bank_irq (irq_bank[b])
    );
  end

  assign im_all     = im_b;
  assign em_all     = em_b;
  assign rt_all     = rt_b;
  assign ft_all     = ft_b;
  assign rp_all     = rp_b;
  assign fp_all     = fp_b;
  assign sw_set_all = sw_b;
  assign rclr_all   = rc_b;
  assign fclr_all   = fc_b;
  assign irq_line   = irq_b;
  assign wake_line  = wake_b;

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit && int'(bank_idx) == b) begin
        case (sel)
          SEL_IMASK: reg_rdata = im_b[b];
          SEL_EMASK: reg_rdata = em_b[b];
          SEL_RTRIG: reg_rdata = rt_b[b];
          SEL_FTRIG: reg_rdata = ft_b[b];
          SEL_RPEND: reg_rdata = rp_b[b];
          SEL_FPEND: reg_rdata = fp_b[b];
          default:   reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/edge_irq_ctrl_sva.sv
module edge_irq_ctrl_sva #(
  parameter int N = 96
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] rise_evt,
  input logic [N-1:0] fall_evt,
  input logic [N-1:0] im_all,
  input logic [N-1:0] em_all,
  input logic [N-1:0] rt_all,
  input logic [N-1:0] ft_all,
  input logic [N-1:0] rp_all,
  input logic [N-1:0] fp_all,
  input logic [N-1:0] sw_set_all,
  input logic [N-1:0] rclr_all,
  input logic [N-1:0] fclr_all,
  input logic         cfg_wr,
  input logic [N-1:0] irq_line,
  input logic [N-1:0] wake_line
);
  a_r2_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_evt & rt_all)) |=>
      ((rp_all & $past(rise_evt & rt_all)) == $past(rise_evt & rt_all)));

  a_r3_fall_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fall_evt & ft_all)) |=>
      ((fp_all & $past(fall_evt & ft_all)) == $past(fall_evt & ft_all)));

  a_r4_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((rp_all & ~$past(rp_all) & ~$past((rise_evt & rt_all) | sw_set_all)) == '0));

  a_r4_no_spurious_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((fp_all & ~$past(fp_all) & ~$past(fall_evt & ft_all)) == '0));

  a_r5_clear_only_written: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rp_all) & ~rp_all & ~$past(rclr_all)) == '0) &&
    (($past(fp_all) & ~fp_all & ~$past(fclr_all)) == '0));

  a_r7_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_set_all) |=> ((rp_all & $past(sw_set_all)) == $past(sw_set_all)));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line & ~im_all) == '0) && ((irq_line & ~(rp_all | fp_all)) == '0));

  a_r8_wake_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_line & ~em_all) == '0) && ((wake_line & ~(rp_all | fp_all)) == '0));

  a_r10_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(im_all) && $stable(em_all) && $stable(rt_all) && $stable(ft_all)));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_sva #(.N(NUM_LINES)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .im_all     (im_all),
  .em_all     (em_all),
  .rt_all     (rt_all),
  .ft_all     (ft_all),
  .rp_all     (rp_all),
  .fp_all     (fp_all),
  .sw_set_all (sw_set_all),
  .rclr_all   (rclr_all),
  .fclr_all   (fclr_all),
  .cfg_wr     (cfg_wr),
  .irq_line   (irq_line),
  .wake_line  (wake_line)
);

// File: tb/tb_edge_irq_ctrl.sv
`timescale 1ns/1ps
module tb_edge_irq_ctrl;
  localparam int NB = 3;
  localparam int BW = 32;
  localparam int NL = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines_in = '0;
  logic          reg_wr = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq_line, wake_line;
  logic [NB-1:0] irq_bank;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #4 clk = ~clk;  // 125 MHz

  edge_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line), .wake_line(wake_line), .irq_bank(irq_bank)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0]   m_im[NB], m_em[NB], m_rt[NB], m_ft[NB], m_rp[NB], m_fp[NB];
  logic [NL-1:0] hist[$];
  logic [NL-1:0] m_rise, m_fall;
  logic [31:0]   m_sw, m_rc, m_fc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_im[b] = 0; m_em[b] = 0; m_rt[b] = 0; m_ft[b] = 0; m_rp[b] = 0; m_fp[b] = 0;
      end
      hist.delete();
      for (int k = 0; k < 4; k++) hist.push_front('0);
    end else begin
      // edge seen by the logic now = level sampled two edges ago vs three ago
      m_rise = hist[1] & ~hist[2];
      m_fall = ~hist[1] & hist[2];
      hist.push_front(lines_in);
      void'(hist.pop_back());
      for (int b = 0; b < NB; b++) begin
        bit hit;
        hit  = reg_wr && (int'(reg_addr[5:3]) == b);
        m_sw = (hit && reg_addr[2:0] == 3'd4) ? reg_wdata : 32'd0;
        m_rc = (hit && reg_addr[2:0] == 3'd5) ? reg_wdata : 32'd0;
        m_fc = (hit && reg_addr[2:0] == 3'd6) ? reg_wdata : 32'd0;
        m_rp[b] = (m_rp[b] & ~m_rc) | (m_rise[b*BW +: BW] & m_rt[b]) | m_sw;
        m_fp[b] = (m_fp[b] & ~m_fc) | (m_fall[b*BW +: BW] & m_ft[b]);
        if (hit) begin
          case (reg_addr[2:0])
            3'd0: m_im[b] = reg_wdata;
            3'd1: m_em[b] = reg_wdata;
            3'd2: m_rt[b] = reg_wdata;
            3'd3: m_ft[b] = reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] model_read(logic [5:0] a);
    int b = int'(a[5:3]);
    if (b >= NB) return 32'd0;
    case (a[2:0])
      3'd0: return m_im[b];
      3'd1: return m_em[b];
      3'd2: return m_rt[b];
      3'd3: return m_ft[b];
      3'd5: return m_rp[b];
      3'd6: return m_fp[b];
      default: return 32'd0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, string tag);
    reg_addr = a;
    #1;
    chk(tag, NL'(reg_rdata), NL'(model_read(a)));
  endtask

  task automatic rd_fix(logic [5:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    chk(tag, NL'(reg_rdata), NL'(exp));
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [5:0] ad(int b, int off);
    return 6'(b * 8 + off);
  endfunction

  // R8: outputs against the reference every clock
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      logic [NL-1:0] ei, ew;
      logic [NL-1:0] eb;
      eb = '0;
      for (int b = 0; b < NB; b++) begin
        ei[b*BW +: BW] = (m_rp[b] | m_fp[b]) & m_im[b];
        ew[b*BW +: BW] = (m_rp[b] | m_fp[b]) & m_em[b];
        eb[b] = |ei[b*BW +: BW];
      end
      chk("R8 irq_line", irq_line, ei);
      chk("R8 wake_line", wake_line, ew);
      chk("R8 irq_bank", NL'(irq_bank), eb);
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lfsr;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1;

    // R1: reset state
    rd_fix(ad(0, 0), 32'd0, "R1 imask");
    rd_fix(ad(1, 2), 32'd0, "R1 rtrig");
    rd_fix(ad(2, 5), 32'd0, "R1 rpend");
    chk("R1 outputs", irq_line | wake_line, '0);

    // configuration, R9 readback
    wr(ad(0, 0), 32'hFFFF_FFFF);
    wr(ad(0, 1), 32'h0F0F_0F0F);
    wr(ad(0, 2), 32'h0000_00FF);
    wr(ad(0, 3), 32'h0000_FF00);
    wr(ad(1, 0), 32'hFFFF_0080);
    wr(ad(1, 2), 32'hFFFF_FFFF);
    wr(ad(2, 0), 32'hFFFF_FFFF);
    wr(ad(2, 2), 32'h0000_0001);
    wr(ad(2, 3), 32'hFFFF_FFFF);
    rd_fix(ad(0, 3), 32'h0000_FF00, "R9 ftrig bank0 readback");
    rd_fix(ad(1, 0), 32'hFFFF_0080, "R9 imask bank1 readback");
    rd_fix(ad(2, 2), 32'h0000_0001, "R9 rtrig bank2 readback");

    // R2: latency of a rising edge on line 3
    @(negedge clk); lines_in[3] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_fix(ad(0, 5), 32'd0, "R2 not yet latched after two edges");
    @(posedge clk); @(negedge clk);
    rd_fix(ad(0, 5), 32'h0000_0008, "R2 latched on third edge");
    chk("R8 bank0 combined irq", NL'(irq_bank), NL'(3'b001));

    // R4: falling on line 3 (no falling enable), line 20 with no enable
    lines_in[3] = 1'b0; lines_in[20] = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); lines_in[20] = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd_fix(ad(0, 6), 32'd0, "R4 no fall latch without enable");
    rd_fix(ad(0, 5), 32'h0000_0008, "R4 no rise latch on line 20");

    // R3: falling on line 10; pulse on bank2 line 0 latches both
    lines_in[10] = 1'b1; lines_in[64] = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); lines_in[10] = 1'b0; lines_in[64] = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd_fix(ad(0, 6), 32'h0000_0400, "R3 falling pending line 10");
    rd_fix(ad(2, 5), 32'h0000_0001, "R3 both-edge pulse rising");
    rd_fix(ad(2, 6), 32'h0000_0001, "R3 both-edge pulse falling");

    // R5: write 0 no effect, write 1 clears one bit only
    wr(ad(0, 5), 32'd0);
    rd_fix(ad(0, 5), 32'h0000_0008, "R5 zero write keeps pending");
    wr(ad(0, 6), 32'h0000_0400);
    rd_fix(ad(0, 6), 32'd0, "R5 cleared falling bit");
    rd_fix(ad(0, 5), 32'h0000_0008, "R5 other register kept");
    rd_fix(ad(2, 6), 32'h0000_0001, "R5 other bank kept");

    // R6: edge and clear meet in the same cycle on bank1 line 7
    @(negedge clk); lines_in[39] = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); lines_in[39] = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); lines_in[39] = 1'b1;
    repeat (2) @(posedge clk);
    wr(ad(1, 5), 32'h0000_0080);
    rd_fix(ad(1, 5), 32'h0000_0080, "R6 set wins over clear");
    wr(ad(1, 5), 32'h0000_0080);
    rd_fix(ad(1, 5), 32'd0, "R5 plain clear");

    // R7: software trigger ignores enables, reads 0
    wr(ad(2, 4), 32'h0000_0020);
    rd_fix(ad(2, 5), 32'h0000_0021, "R7 software trigger sets rising pending");
    wr(ad(2, 4), 32'd0);
    rd_fix(ad(2, 5), 32'h0000_0021, "R7 zero write no effect");
    rd_fix(ad(2, 4), 32'd0, "R7 trigger register reads 0");

    // R9: offset 7 and bank 3 ignored
    wr(ad(0, 7), 32'hDEAD_BEEF);
    wr(ad(3, 0), 32'h1234_5678);
    wr(ad(3, 4), 32'hFFFF_FFFF);
    rd_fix(ad(0, 7), 32'd0, "R9 unused offset reads 0");
    rd_fix(ad(3, 0), 32'd0, "R9 absent bank reads 0");
    rd_fix(ad(0, 0), 32'hFFFF_FFFF, "R9 absent bank write leaves bank0");
    rd_fix(ad(1, 5), 32'd0, "R9 absent bank trigger leaves bank1");

    // R10: configuration survives clears and software triggers
    rd_fix(ad(0, 2), 32'h0000_00FF, "R10 rtrig bank0 intact");
    rd_fix(ad(2, 3), 32'hFFFF_FFFF, "R10 ftrig bank2 intact");
    rd_fix(ad(0, 1), 32'h0F0F_0F0F, "R10 emask bank0 intact");

    // pseudo-random activity on every line
    wr(ad(1, 1), 32'hAAAA_5555);
    wr(ad(1, 3), 32'h00FF_FF00);
    wr(ad(2, 1), 32'h3C3C_3C3C);
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lines_in = lines_in ^ {lfsr & {lfsr[7:0], lfsr[31:8]},
                             lfsr & {lfsr[15:0], lfsr[31:16]},
                             lfsr & {lfsr[3:0], lfsr[31:4]}};
      if (i % 37 == 5) begin
        reg_wr = 1'b1; reg_addr = ad(i % 3, 5 + (i % 2)); reg_wdata = lfsr;
      end else begin
        reg_wr = 1'b0;
      end
    end
    @(negedge clk); reg_wr = 1'b0;
    for (int b = 0; b < NB; b++) begin
      rd(ad(b, 5), "R2 random rising pending");
      rd(ad(b, 6), "R3 random falling pending");
    end
    for (int b = 0; b < NB; b++) begin
      wr(ad(b, 5), 32'hFFFF_FFFF);
      wr(ad(b, 6), 32'hFFFF_FFFF);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NB; b++) rd(ad(b, 5), "R5 pending after bulk clear");

    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule